// File: doc/BRIEF.md
# Four-Way Rotating Traffic Light Controller

This block runs the signal heads at a four-way junction. One approach at a time is served. It shows green for a fixed number of clock cycles, then yellow for a fixed number, while the other three approaches stay red. Service then passes to the next approach in a fixed rotation: north, south, east, west, and back to north. The only inputs are a clock and a synchronous active-high reset. Each approach has its own 3-bit one-hot lamp output.

The state has two parts: the approach being served with its phase, and a cycle counter that starts again at every phase change. While reset is held the block shows north green with the counter at zero. The cycle in which reset is released is the first green cycle of north.

Top module: `traffic_light_ctrl`

## Requirements
- R1: Every lamp output carries one of three one-hot codes: 3'b001 for green, 3'b010 for yellow, 3'b100 for red.
- R2: A green phase stays visible for exactly GREEN_CYCLES (default 8) consecutive cycles, unless reset cuts it short.
- R3: A yellow phase stays visible for exactly YELLOW_CYCLES (default 4) consecutive cycles, unless reset cuts it short.
- R4: Service rotates north, then south, then east, then west, then north again, with no end.
- R5: In every cycle exactly one approach is not red. A green on one approach is always followed by yellow on that same approach.
- R6: In any cycle after a clock edge that sampled reset high, north shows green and south, east and west show red.
- R7: The cycle in which reset is released counts as the first of north's GREEN_CYCLES green cycles, so yellow first appears GREEN_CYCLES cycles after release.
- R8: Reset sampled on the same edge that ends a phase takes priority. The next cycle shows north green with the counter restarted, not the next phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| north_lamp | output | 3 | North lamp code (001 green, 010 yellow, 100 red) |
| south_lamp | output | 3 | South lamp code |
| east_lamp | output | 3 | East lamp code |
| west_lamp | output | 3 | West lamp code |

## Verification
Two events can fall on one clock edge: the phase counter reaching its terminal count, and reset. The bench sets up this collision directly, asserting reset in the last green cycle of north and in the last yellow cycle of north. It then expects north green with a restarted count, where the phase advance would have given yellow or south green. Random reset pulses are also laid over long free runs, so that reset meets every phase boundary. Each sampled cycle is judged against a closed-form schedule indexed by the number of cycles since the last reset.

// File: rtl/tl_pkg.sv
package tl_pkg;

    localparam int NUM_DIRS = 4;

    typedef enum logic [2:0] {
        LAMP_GREEN  = 3'b001,
        LAMP_YELLOW = 3'b010,
        LAMP_RED    = 3'b100
    } lamp_t;

    // Encoding order is the rotation order; increment wraps west to north.
    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_S = 2'd1,
        DIR_E = 2'd2,
        DIR_W = 2'd3
    } dir_t;

    typedef enum logic {
        PH_GO      = 1'b0,
        PH_CAUTION = 1'b1
    } phase_t;

    typedef struct packed {
        dir_t   dir;
        phase_t phase;
    } svc_t;

    localparam svc_t SVC_RESET = '{dir: DIR_N, phase: PH_GO};

    function automatic dir_t next_dir(input dir_t d);
        return dir_t'(d + 2'd1);
    endfunction

    function automatic lamp_t lamp_for(input svc_t s, input dir_t me);
        if (s.dir != me)
            return LAMP_RED;
        return (s.phase == PH_GO) ? LAMP_GREEN : LAMP_YELLOW;
    endfunction

    function automatic svc_t advance(input svc_t s);
        svc_t n;
        if (s.phase == PH_GO) begin
            n.dir   = s.dir;
            n.phase = PH_CAUTION;
        end else begin
            n.dir   = next_dir(s.dir);
            n.phase = PH_GO;
        end
        return n;
    endfunction

endpackage

// File: rtl/tl_phase_timer.sv
module tl_phase_timer
    import tl_pkg::*;
#(
    parameter int GREEN_CYCLES  = 8,
    parameter int YELLOW_CYCLES = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase,
    output logic   last
);
    localparam int MAXC = (GREEN_CYCLES > YELLOW_CYCLES) ? GREEN_CYCLES : YELLOW_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] G_LAST = CW'(GREEN_CYCLES - 1);
    localparam logic [CW-1:0] Y_LAST = CW'(YELLOW_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        limit = (phase == PH_GO) ? G_LAST : Y_LAST;
        last  = (cnt == limit);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/tl_sequencer.sv
module tl_sequencer
    import tl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic last,
    output svc_t svc
);
    always_ff @(posedge clk) begin
        if (rst)
            svc <= SVC_RESET;
        else if (last)
            svc <= advance(svc);
    end

endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
    import tl_pkg::*;
(
    input  svc_t                        svc,
    output logic [NUM_DIRS-1:0][2:0]    lamps
);
    for (genvar i = 0; i < NUM_DIRS; i++) begin : g_dir
        localparam logic [1:0] ME = 2'(i);
        assign lamps[i] = lamp_for(svc, dir_t'(ME));
    end

endmodule

// File: rtl/traffic_light_ctrl.sv
module traffic_light_ctrl
    import tl_pkg::*;
#(
    parameter int GREEN_CYCLES  = 8,
    parameter int YELLOW_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    output logic [2:0] north_lamp,
    output logic [2:0] south_lamp,
    output logic [2:0] east_lamp,
    output logic [2:0] west_lamp
);
    svc_t                     svc;
    logic                     last;
    logic [NUM_DIRS-1:0][2:0] lamps;

    tl_phase_timer #(
        .GREEN_CYCLES (GREEN_CYCLES),
        .YELLOW_CYCLES(YELLOW_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .phase(svc.phase),
        .last (last)
    );

    tl_sequencer u_seq (
        .clk (clk),
        .rst (rst),
        .last(last),
        .svc (svc)
    );

    tl_lamp_decode u_dec (
        .svc  (svc),
        .lamps(lamps)
    );

    assign north_lamp = lamps[DIR_N];
    assign south_lamp = lamps[DIR_S];
    assign east_lamp  = lamps[DIR_E];
    assign west_lamp  = lamps[DIR_W];

endmodule

// File: rtl/tl_checker.sv
module tl_checker #(
    parameter int GREEN_CYCLES  = 8,
    parameter int YELLOW_CYCLES = 4
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] north_lamp,
    input logic [2:0] south_lamp,
    input logic [2:0] east_lamp,
    input logic [2:0] west_lamp
);
    localparam logic [2:0] C_G = 3'b001;
    localparam logic [2:0] C_Y = 3'b010;
    localparam logic [2:0] C_R = 3'b100;
    localparam logic [2:0] KEY_NG = 3'b000;

    logic [3:0] lit;
    logic [2:0] key, prev_key;
    int         run;

    function automatic logic legal(input logic [2:0] c);
        return (c == C_G) || (c == C_Y) || (c == C_R);
    endfunction

    always_comb begin
        lit = {west_lamp != C_R, east_lamp != C_R, south_lamp != C_R, north_lamp != C_R};
        key = KEY_NG;
        if (south_lamp != C_R) key = {2'd1, south_lamp == C_Y};
        if (east_lamp  != C_R) key = {2'd2, east_lamp  == C_Y};
        if (west_lamp  != C_R) key = {2'd3, west_lamp  == C_Y};
        if (north_lamp != C_R) key = {2'd0, north_lamp == C_Y};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_key <= KEY_NG;
            run      <= 0;
        end else begin
            prev_key <= key;
            run      <= (key == prev_key) ? run + 1 : 1;
        end
    end

    a_r1_legal_codes: assert property (@(posedge clk) disable iff (rst)
        legal(north_lamp) && legal(south_lamp) && legal(east_lamp) && legal(west_lamp));

    a_r5_single_lit: assert property (@(posedge clk) disable iff (rst)
        $countones(lit) == 1);

    a_r6_reset_north: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (north_lamp == C_G && south_lamp == C_R &&
                        east_lamp == C_R && west_lamp == C_R));

    a_r2_green_len: assert property (@(posedge clk) disable iff (rst)
        (key != prev_key && !prev_key[0]) |-> run == GREEN_CYCLES);

    a_r2_green_bound: assert property (@(posedge clk) disable iff (rst)
        (key == prev_key && !key[0]) |-> run < GREEN_CYCLES);

    a_r3_yellow_len: assert property (@(posedge clk) disable iff (rst)
        (key != prev_key && prev_key[0]) |-> run == YELLOW_CYCLES);

    a_r3_yellow_bound: assert property (@(posedge clk) disable iff (rst)
        (key == prev_key && key[0]) |-> run < YELLOW_CYCLES);

    a_r5_green_to_yellow: assert property (@(posedge clk) disable iff (rst)
        (key != prev_key && !prev_key[0]) |-> key == {prev_key[2:1], 1'b1});

    a_r4_rotation: assert property (@(posedge clk) disable iff (rst)
        (key != prev_key && prev_key[0]) |-> key == {prev_key[2:1] + 2'd1, 1'b0});

endmodule

bind traffic_light_ctrl tl_checker #(
    .GREEN_CYCLES (GREEN_CYCLES),
    .YELLOW_CYCLES(YELLOW_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .north_lamp(north_lamp),
    .south_lamp(south_lamp),
    .east_lamp (east_lamp),
    .west_lamp (west_lamp)
);

// File: tb/sim_traffic_light_ctrl.sv
module sim_traffic_light_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int G   = 8;
    localparam int Y   = 4;
    localparam int PER = G + Y;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] north_lamp, south_lamp, east_lamp, west_lamp;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  k       = 0;
    bit  done    = 1'b0;

    traffic_light_ctrl #(.GREEN_CYCLES(G), .YELLOW_CYCLES(Y)) u0 (
        .clk(clk), .rst(rst),
        .north_lamp(north_lamp), .south_lamp(south_lamp),
        .east_lamp(east_lamp), .west_lamp(west_lamp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Closed-form schedule: kk cycles since the last reset edge.
    function automatic logic [2:0] exp_lamp(input int kk, input int d);
        int slot = kk % (4 * PER);
        if (slot / PER != d) return 3'b100;
        return ((slot % PER) < G) ? 3'b001 : 3'b010;
    endfunction

    function automatic logic [2:0] lamp_of(input int d);
        case (d)
            0: return north_lamp;
            1: return south_lamp;
            2: return east_lamp;
            default: return west_lamp;
        endcase
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s k=%0d actual=%h expected=%h", req, k, act, exp);
        end
    endtask

    task automatic check_cycle(input logic held);
        logic [11:0] a, e;
        string tag;
        for (int d = 0; d < 4; d++) begin
            a[d*3 +: 3] = lamp_of(d);
            e[d*3 +: 3] = exp_lamp(k, d);
        end
        if (held) tag = "R6";
        else if ((k % PER) < G) tag = "R2/R5";
        else tag = "R3/R5";
        check(tag, a, e);
    endtask

    // At a negedge: drive rst, cross a posedge, sample at the next negedge.
    task automatic step(input logic r);
        rst = r;
        @(posedge clk);
        if (r) k = 0; else k++;
        @(negedge clk);
        check_cycle(r);
    endtask

    initial begin
        void'($urandom(32'd20131107));
        @(negedge clk);
        step(1'b1);
        step(1'b1);
        // R6: reset held shows north green, the rest red
        check("R6", {west_lamp, east_lamp, south_lamp, north_lamp}, {3'b100, 3'b100, 3'b100, 3'b001});

        // R7: release; green persists through k = G-1, yellow at k = G
        for (int i = 0; i < G - 1; i++) step(1'b0);
        check("R7", {9'd0, north_lamp}, {9'd0, 3'b001});
        step(1'b0);
        check("R7", {9'd0, north_lamp}, {9'd0, 3'b010});
        // R1: exact code values
        check("R1", {6'd0, south_lamp, north_lamp}, {6'd0, 3'b100, 3'b010});

        // R4: rotation south, east, west, north at phase starts
        for (int d = 1; d <= 4; d++) begin
            while (k < d * PER) step(1'b0);
            check("R4", {9'd0, lamp_of(d % 4)}, {9'd0, 3'b001});
        end

        // R8: reset on north's last green cycle beats the green->yellow advance
        step(1'b1);
        for (int i = 0; i < G - 1; i++) step(1'b0);
        step(1'b1);
        check("R8", {9'd0, north_lamp}, {9'd0, 3'b001});
        // R8: reset on north's last yellow cycle beats the hand-off to south
        for (int i = 0; i < PER - 1; i++) step(1'b0);
        step(1'b1);
        check("R8", {north_lamp, south_lamp, 6'd0}, {3'b001, 3'b100, 6'd0});
        for (int i = 0; i < G; i++) step(1'b0);
        check("R8", {9'd0, north_lamp}, {9'd0, 3'b010});

        // Random reset pulses over long free runs
        for (int i = 0; i < 3000; i++)
            step(($urandom % 37) == 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R4 actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule